// File: doc/BRIEF.md
# Jittered Fixed-Frequency PWM Generator

This block produces the gate-drive waveform of a peak-current-mode switching converter. A select input picks one of two nominal switching frequencies: 60 kHz for the low variant and 115 kHz for the high variant. While the block runs, the switching period is swept slowly up and down along a triangular profile around that nominal value. Each harmonic of the switching frequency is therefore spread over a band of neighbouring frequencies.

Every switching cycle begins with the gate high. The gate goes low on the first of these events:
- a current-sense trip that arrives after the blanking window and after the minimum on-time;
- the duty-cycle ceiling;
- the enable input going low.

The block emits a one-clock pulse at the start of each cycle. It also drives a level that is high while the switch is off inside a running cycle, so that neighbouring blocks (strobed comparators, for example) can time their sampling. Analog current sensing appears only as the single-bit `trip` flag.

All timing is counted in clock cycles. The default parameters assume a 10 MHz clock, so one count is 100 ns. The triangle sweep advances the period by a fixed fractional increment on each switching cycle. The increment is computed so that one full up-and-down sweep lasts about 4 ms, which gives a modulation rate of about 250 Hz.

Top module: `jitter_pwm`

## Requirements
- R1: With the low variant (`hiSel`=0), every cycle period lies between 156 and 178 clocks, which is 64 kHz to 56 kHz. With the high variant (`hiSel`=1), every period lies between 81 and 93 clocks, which is 123 kHz to 107 kHz.
- R2: A sweep position in units of 1/256 clock starts at 0 after reset. At each cycle start, the period of the new cycle is the minimum period plus floor(position/256). The position then moves by a fixed step: 46 for the low variant, 13 for the high variant. It clamps at span×256, where the span is 22 or 12, and at 0, and reverses direction at each clamp. The first cycle after reset therefore uses the minimum period.
- R3: The sweep reaches the maximum period on cycle index 123 for the low variant and on cycle index 237 for the high variant, counting cycles from 0. The preceding cycle is one clock shorter. One half sweep thus spans about the number of switching cycles that fit in 2 ms.
- R4: At each cycle start, `gate` rises and `cycleStart` is high for exactly that one clock.
- R5: On-time never exceeds floor(0.8 × period) clocks. With no trip, the gate is high for exactly that many clocks.
- R6: Once the gate rises, it stays high for at least 4 clocks (400 ns), even when `trip` is held high from the cycle start.
- R7: A trip that is present only during the first 3 clocks of a cycle (300 ns of blanking) is ignored, and the gate runs on to the duty ceiling.
- R8: A trip sampled at the clock edge that ends clock k of the cycle, where k ≥ 3 and k is counted from 0 at the cycle start, ends the on-time after k+1 clocks.
- R9: `offTime` is high on every clock of a running cycle in which the gate is low. It is low while the gate is high and while the block is disabled.
- R10: While `en` is low, `gate` is low in the same clock. No cycle starts, `offTime` is low from the next clock, and the sweep position is frozen. The first clock edge with `en` high again starts a new cycle, using the frozen position.
- R11: During reset, `gate`, `cycleStart` and `offTime` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; a count of 1 is one period of this clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hiSel | input | 1 | Variant select: 0 for 60 kHz nominal, 1 for 115 kHz nominal |
| en | input | 1 | Run enable; when low, the gate is forced low and the sweep is frozen |
| trip | input | 1 | Current-sense comparator flag, high when peak current is reached |
| gate | output | 1 | Switch gate drive |
| cycleStart | output | 1 | One-clock pulse on the first clock of each cycle |
| offTime | output | 1 | High while the switch is off inside a running cycle |

## Verification
The assertions assume that `hiSel` is held constant for as long as the block runs, and that it changes only under reset. Without that, a period measured across a variant change could fall outside either window. The stimulus changes the variant only while `rstN` is low. The blanking and minimum on-time properties assume that the gate rises only at a cycle start. The trip pulses are therefore placed relative to the observed `cycleStart`, at fixed clock offsets that lie inside the blanking window, on its edge, and beyond it. The enable is dropped in the middle of an on-time, so that the duty-ratio property is re-armed only once a full undisturbed cycle has elapsed again.

// File: rtl/jitter_pwm_pkg.sv
package jitter_pwm_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic startCyc;  // begin a new switching cycle this edge
    logic idle;      // block disabled: hold counter at zero
  } pwmStrobe_t;

  // comparisons from datapath to control
  typedef struct packed {
    logic lastCnt;   // current clock is the last of the period
    logic blankOk;   // blanking window has elapsed
    logic minOk;     // minimum on-time reached after this clock
    logic capHit;    // duty ceiling reached after this clock
  } pwmFlags_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/jitter_pwm_dp.sv
module jitter_pwm_dp
  import jitter_pwm_pkg::*;
#(
  parameter int CLK_KHZ    = 10000,
  parameter int LO_KHZ     = 60,
  parameter int HI_KHZ     = 115,
  parameter int LO_DEV_KHZ = 4,
  parameter int HI_DEV_KHZ = 8,
  parameter int MOD_HZ     = 250,
  parameter int DUTY_PCT   = 80,
  parameter int MINON_NS   = 400,
  parameter int BLANK_NS   = 300,
  parameter int FRAC_W     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hiSel,
  input  pwmStrobe_t strobe,
  output pwmFlags_t  flags
);

  // period limits in clocks (fastest frequency gives the shortest period)
  localparam int LO_PMIN  = CLK_KHZ / (LO_KHZ + LO_DEV_KHZ);
  localparam int LO_PMAX  = CLK_KHZ / (LO_KHZ - LO_DEV_KHZ);
  localparam int HI_PMIN  = CLK_KHZ / (HI_KHZ + HI_DEV_KHZ);
  localparam int HI_PMAX  = CLK_KHZ / (HI_KHZ - HI_DEV_KHZ);
  // sweep span in fractional units, and switching cycles per half sweep
  localparam int LO_SPANQ = (LO_PMAX - LO_PMIN) << FRAC_W;
  localparam int HI_SPANQ = (HI_PMAX - HI_PMIN) << FRAC_W;
  localparam int LO_HALF  = (LO_KHZ * 1000) / (2 * MOD_HZ);
  localparam int HI_HALF  = (HI_KHZ * 1000) / (2 * MOD_HZ);
  localparam int LO_STEPR = LO_SPANQ / LO_HALF;
  localparam int HI_STEPR = HI_SPANQ / HI_HALF;
  localparam int LO_STEP  = (LO_STEPR < 1) ? 1 : LO_STEPR;
  localparam int HI_STEP  = (HI_STEPR < 1) ? 1 : HI_STEPR;
  // widths
  localparam int PMAX_ALL = maxInt(LO_PMAX, HI_PMAX);
  localparam int QMAX_ALL = maxInt(LO_SPANQ + LO_STEP, HI_SPANQ + HI_STEP);
  localparam int PER_W    = $clog2(PMAX_ALL + 1);
  localparam int POS_W    = $clog2(QMAX_ALL + 1);
  // on-time guards in clocks
  localparam int MINON_CNT = (MINON_NS * CLK_KHZ) / 1000000;
  localparam int BLANK_CNT = (BLANK_NS * CLK_KHZ) / 1000000;
  localparam int MINON_M1  = (MINON_CNT < 1) ? 0 : MINON_CNT - 1;
  localparam logic [PER_W-1:0] BLANK_C = PER_W'(BLANK_CNT);
  localparam logic [PER_W-1:0] MINON_C = PER_W'(MINON_M1);

  logic [POS_W-1:0] pos, posNext, spanQ, stepQ;
  logic             goingDown, downNext;
  logic [PER_W-1:0] pmin, perNext, capNext;
  logic [PER_W-1:0] cnt, per, cap;

  // variant constants
  assign spanQ = hiSel ? POS_W'(HI_SPANQ) : POS_W'(LO_SPANQ);
  assign stepQ = hiSel ? POS_W'(HI_STEP)  : POS_W'(LO_STEP);
  assign pmin  = hiSel ? PER_W'(HI_PMIN)  : PER_W'(LO_PMIN);

  // triangular sweep: move by one step, clamp and reverse at the ends
  always_comb begin
    posNext  = pos;
    downNext = goingDown;
    if (!goingDown) begin
      if (pos + stepQ >= spanQ) begin
        posNext  = spanQ;
        downNext = 1'b1;
      end else begin
        posNext = pos + stepQ;
      end
    end else begin
      if (pos <= stepQ) begin
        posNext  = '0;
        downNext = 1'b0;
      end else begin
        posNext = pos - stepQ;
      end
    end
  end

  assign perNext = pmin + PER_W'(pos >> FRAC_W);
  assign capNext = PER_W'((32'(perNext) * 32'(DUTY_PCT)) / 32'd100);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos       <= '0;
      goingDown <= 1'b0;
      cnt       <= '0;
      per       <= '0;
      cap       <= '0;
    end else if (strobe.startCyc) begin
      pos       <= posNext;
      goingDown <= downNext;
      per       <= perNext;
      cap       <= capNext;
      cnt       <= '0;
    end else if (strobe.idle) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + PER_W'(1);
    end
  end

  assign flags.lastCnt = (cnt == per - PER_W'(1));
  assign flags.blankOk = (cnt >= BLANK_C);
  assign flags.minOk   = (cnt >= MINON_C);
  assign flags.capHit  = ((cnt + PER_W'(1)) >= cap);

endmodule

// File: rtl/jitter_pwm_ctrl.sv
module jitter_pwm_ctrl
  import jitter_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       en,
  input  logic       trip,
  input  pwmFlags_t  flags,
  output pwmStrobe_t strobe,
  output logic       gateQ,
  output logic       startQ,
  output logic       active
);

  logic tripValid;

  assign strobe.idle     = !en;
  assign strobe.startCyc = en && (!active || flags.lastCnt);
  assign tripValid       = trip && flags.blankOk && flags.minOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      gateQ  <= 1'b0;
      startQ <= 1'b0;
    end else if (!en) begin
      active <= 1'b0;
      gateQ  <= 1'b0;
      startQ <= 1'b0;
    end else if (strobe.startCyc) begin
      active <= 1'b1;
      gateQ  <= 1'b1;
      startQ <= 1'b1;
    end else begin
      startQ <= 1'b0;
      if (gateQ && (tripValid || flags.capHit)) gateQ <= 1'b0;
    end
  end

endmodule

// File: rtl/jitter_pwm.sv
module jitter_pwm
  import jitter_pwm_pkg::*;
#(
  parameter int CLK_KHZ    = 10000,
  parameter int LO_KHZ     = 60,
  parameter int HI_KHZ     = 115,
  parameter int LO_DEV_KHZ = 4,
  parameter int HI_DEV_KHZ = 8,
  parameter int MOD_HZ     = 250,
  parameter int DUTY_PCT   = 80,
  parameter int MINON_NS   = 400,
  parameter int BLANK_NS   = 300,
  parameter int FRAC_W     = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic hiSel,
  input  logic en,
  input  logic trip,
  output logic gate,
  output logic cycleStart,
  output logic offTime
);

  pwmStrobe_t strobe;
  pwmFlags_t  flags;
  logic       gateQ, startQ, active;

  jitter_pwm_dp #(
    .CLK_KHZ(CLK_KHZ), .LO_KHZ(LO_KHZ), .HI_KHZ(HI_KHZ),
    .LO_DEV_KHZ(LO_DEV_KHZ), .HI_DEV_KHZ(HI_DEV_KHZ), .MOD_HZ(MOD_HZ),
    .DUTY_PCT(DUTY_PCT), .MINON_NS(MINON_NS), .BLANK_NS(BLANK_NS),
    .FRAC_W(FRAC_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .hiSel(hiSel), .strobe(strobe), .flags(flags)
  );

  jitter_pwm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .en(en), .trip(trip), .flags(flags),
    .strobe(strobe), .gateQ(gateQ), .startQ(startQ), .active(active)
  );

  assign gate       = gateQ & en;
  assign cycleStart = startQ;
  assign offTime    = active & ~gateQ;

endmodule

// File: rtl/jitter_pwm_chk.sv
module jitter_pwm_chk #(
  parameter int CLK_KHZ    = 10000,
  parameter int LO_KHZ     = 60,
  parameter int HI_KHZ     = 115,
  parameter int LO_DEV_KHZ = 4,
  parameter int HI_DEV_KHZ = 8,
  parameter int DUTY_PCT   = 80,
  parameter int MINON_NS   = 400,
  parameter int BLANK_NS   = 300
) (
  input logic clk,
  input logic rstN,
  input logic hiSel,
  input logic en,
  input logic gate,
  input logic cycleStart,
  input logic offTime
);

  localparam int LO_PMIN   = CLK_KHZ / (LO_KHZ + LO_DEV_KHZ);
  localparam int LO_PMAX   = CLK_KHZ / (LO_KHZ - LO_DEV_KHZ);
  localparam int HI_PMIN   = CLK_KHZ / (HI_KHZ + HI_DEV_KHZ);
  localparam int HI_PMAX   = CLK_KHZ / (HI_KHZ - HI_DEV_KHZ);
  localparam int MINON_CNT = (MINON_NS * CLK_KHZ) / 1000000;
  localparam int BLANK_CNT = (BLANK_NS * CLK_KHZ) / 1000000;

  logic [15:0] onLen, cycLen, onAcc;
  logic        clean;
  int          pminSel, pmaxSel;

  assign pminSel = hiSel ? HI_PMIN : LO_PMIN;
  assign pmaxSel = hiSel ? HI_PMAX : LO_PMAX;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onLen  <= '0;
      cycLen <= '0;
      onAcc  <= '0;
      clean  <= 1'b0;
    end else begin
      onLen <= gate ? onLen + 16'd1 : 16'd0;
      if (cycleStart) begin
        cycLen <= 16'd1;
        onAcc  <= {15'd0, gate};
      end else begin
        cycLen <= cycLen + 16'd1;
        onAcc  <= onAcc + {15'd0, gate};
      end
      if (!en) clean <= 1'b0;
      else if (cycleStart) clean <= 1'b1;
    end
  end

  // R1: measured period stays inside the selected window
  assert_period_window_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStart && clean && en) |-> (int'(cycLen) >= pminSel && int'(cycLen) <= pmaxSel));

  // R4: a cycle start comes with the gate high, for one clock only
  assert_start_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStart && en) |-> gate);
  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |=> !cycleStart);

  // R5: on-time within a full cycle respects the duty ceiling
  assert_duty_cap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStart && clean && en) |-> (32'(onAcc) * 100 <= 32'(DUTY_PCT) * 32'(cycLen)));

  // R6: a gate fall while enabled follows at least the minimum on-time
  assert_min_on_R6: assert property (@(posedge clk) disable iff (!rstN)
    (en && $past(en) && $past(gate) && !gate) |-> (int'(onLen) >= MINON_CNT));

  // R7: inside the blanking window the gate cannot fall unless disabled
  assert_blank_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (gate && en && int'(onLen) < BLANK_CNT) |=> (gate || !en));

  // R9: an enabled turn-off inside a cycle raises the off-time level
  assert_off_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    (en && $past(en) && !cycleStart && $past(gate) && !gate) |-> offTime);

  // R10: disable stops cycle starts and clears the off-time level
  assert_disable_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (!cycleStart && !offTime));

endmodule

bind jitter_pwm jitter_pwm_chk #(
  .CLK_KHZ(CLK_KHZ), .LO_KHZ(LO_KHZ), .HI_KHZ(HI_KHZ),
  .LO_DEV_KHZ(LO_DEV_KHZ), .HI_DEV_KHZ(HI_DEV_KHZ),
  .DUTY_PCT(DUTY_PCT), .MINON_NS(MINON_NS), .BLANK_NS(BLANK_NS)
) uChk (
  .clk(clk), .rstN(rstN), .hiSel(hiSel), .en(en),
  .gate(gate), .cycleStart(cycleStart), .offTime(offTime)
);

// File: tb/tb_jitter_pwm.sv
`timescale 1ns/1ps
module tb_jitter_pwm;

  logic clk = 1'b0;
  logic rstN, hiSel, en, trip;
  logic gate, cycleStart, offTime;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  jitter_pwm dut (
    .clk(clk), .rstN(rstN), .hiSel(hiSel), .en(en), .trip(trip),
    .gate(gate), .cycleStart(cycleStart), .offTime(offTime)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // ---------------- behavioural reference ----------------
  int mCnt, mPer, mCap, mPos;
  bit mAct, mGate, mStart, mDown;

  always @(posedge clk or negedge rstN) begin
    int pminV, spanQV, stepV;
    if (!rstN) begin
      mAct = 0; mGate = 0; mStart = 0; mDown = 0;
      mCnt = 0; mPer = 0; mCap = 0; mPos = 0;
    end else if (!en) begin
      mAct = 0; mGate = 0; mStart = 0; mCnt = 0;
    end else if (!mAct || mCnt == mPer - 1) begin
      pminV  = hiSel ? 10000 / 123 : 10000 / 64;
      spanQV = hiSel ? 12 * 256 : 22 * 256;
      stepV  = hiSel ? 13 : 46;
      mPer = pminV + mPos / 256;
      mCap = (mPer * 80) / 100;
      if (!mDown) begin
        if (mPos + stepV >= spanQV) begin mPos = spanQV; mDown = 1; end
        else mPos = mPos + stepV;
      end else begin
        if (mPos <= stepV) begin mPos = 0; mDown = 0; end
        else mPos = mPos - stepV;
      end
      mCnt = 0; mAct = 1; mGate = 1; mStart = 1;
    end else begin
      mStart = 0;
      if (mGate && ((trip && mCnt >= 3) || mCnt + 1 >= mCap)) mGate = 0;
      mCnt++;
    end
  end

  // ---------------- monitor and statistics ----------------
  int clkIdx = 0, lastStart = 0, onRun = 0, startCount = 0;
  bit haveStart = 0;
  int perQ[$];
  int onQ[$];

  task automatic clearStats();
    perQ.delete(); onQ.delete();
    haveStart = 0; startCount = 0; onRun = 0;
  endtask

  always @(negedge clk) begin
    clkIdx++;
    if (rstN) begin
      chk(gate == (mGate && en), "R4 gate vs reference", int'(gate), int'(mGate && en));
      chk(cycleStart == mStart, "R4 cycleStart vs reference", int'(cycleStart), int'(mStart));
      chk(offTime == (mAct && !mGate), "R9 offTime vs reference", int'(offTime), int'(mAct && !mGate));
      if (cycleStart) begin
        if (haveStart) begin
          perQ.push_back(clkIdx - lastStart);
          onQ.push_back(onRun);
        end
        haveStart = 1; lastStart = clkIdx; onRun = 0; startCount++;
      end
      if (gate) onRun++;
    end
  end

  task automatic waitStarts(input int n);
    while (startCount < n) @(negedge clk);
    #1;
  endtask

  task automatic waitStartEdge();
    do @(negedge clk); while (!cycleStart);
    #1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog actual=timeout expected=finish");
    finishRun();
  end

  // ---------------- stimulus ----------------
  initial begin
    int mx, mn, bad, expPer;
    rstN = 0; hiSel = 0; en = 0; trip = 0;
    repeat (3) @(negedge clk);
    chk(!gate && !cycleStart && !offTime, "R11 outputs low in reset",
        int'({gate, cycleStart, offTime}), 0);
    @(posedge clk); #1 rstN = 1;
    repeat (5) @(negedge clk);
    chk(!gate && !cycleStart && !offTime, "R10 idle while disabled",
        int'({gate, cycleStart, offTime}), 0);

    // ---- low variant sweep ----
    clearStats();
    @(posedge clk); #1 en = 1;
    waitStarts(261);
    chk(perQ[0] == 156, "R2 first period low", perQ[0], 156);
    chk(onQ[0] == 124, "R5 first on-time low", onQ[0], 124);
    chk(perQ[122] == 177, "R3 period before top low", perQ[122], 177);
    chk(perQ[123] == 178, "R3 top period low", perQ[123], 178);
    chk(perQ[124] == 177, "R2 reversal after top low", perQ[124], 177);
    mx = 0; mn = 100000; bad = 0;
    foreach (perQ[k]) begin
      if (perQ[k] > mx) mx = perQ[k];
      if (perQ[k] < mn) mn = perQ[k];
      if (onQ[k] != (perQ[k] * 80) / 100) bad++;
    end
    chk(mx == 178, "R1 max period low", mx, 178);
    chk(mn == 156, "R1 min period low", mn, 156);
    chk(bad == 0, "R5 on-time equals duty ceiling", bad, 0);

    // ---- R7: trip only during blanking ----
    waitStartEdge();
    trip = 1;
    repeat (3) @(negedge clk);
    trip = 0;
    waitStartEdge();
    chk(onQ[$] == (perQ[$] * 80) / 100, "R7 blanked trip ignored", onQ[$], (perQ[$] * 80) / 100);

    // ---- R6: trip held from cycle start ----
    trip = 1;
    waitStartEdge();
    trip = 0;
    chk(onQ[$] == 4, "R6 minimum on-time", onQ[$], 4);

    // ---- R8: trip at clock 5 and at clock 10 ----
    waitStartEdge();
    repeat (5) @(negedge clk);
    trip = 1;
    @(negedge clk);
    trip = 0;
    waitStartEdge();
    chk(onQ[$] == 6, "R8 trip at clock 5", onQ[$], 6);
    repeat (10) @(negedge clk);
    trip = 1;
    @(negedge clk);
    trip = 0;
    waitStartEdge();
    chk(onQ[$] == 11, "R8 trip at clock 10", onQ[$], 11);

    // ---- R10: disable mid on-time ----
    repeat (20) @(negedge clk);
    @(posedge clk); #1 en = 0;
    @(negedge clk);
    chk(gate == 0, "R10 gate low same clock", int'(gate), 0);
    bad = 0;
    repeat (30) begin
      @(negedge clk);
      if (cycleStart || offTime || gate) bad++;
    end
    chk(bad == 0, "R10 quiet while disabled", bad, 0);
    clearStats();
    @(posedge clk); #1 en = 1;
    @(negedge clk);
    @(negedge clk);
    chk(cycleStart == 1 && gate == 1, "R10 restart on first enabled edge",
        int'({cycleStart, gate}), 3);
    #1 expPer = mPer;
    waitStarts(2);
    chk(perQ[0] == expPer, "R10 sweep frozen across disable", perQ[0], expPer);

    // ---- high variant sweep ----
    @(posedge clk); #1 en = 0; rstN = 0;
    @(posedge clk); #1 hiSel = 1;
    @(posedge clk); #1 rstN = 1;
    clearStats();
    @(posedge clk); #1 en = 1;
    waitStarts(241);
    chk(perQ[0] == 81, "R2 first period high", perQ[0], 81);
    chk(onQ[0] == 64, "R5 first on-time high", onQ[0], 64);
    chk(perQ[236] == 92, "R3 period before top high", perQ[236], 92);
    chk(perQ[237] == 93, "R3 top period high", perQ[237], 93);
    chk(perQ[238] == 92, "R2 reversal after top high", perQ[238], 92);
    mx = 0; mn = 100000;
    foreach (perQ[k]) begin
      if (perQ[k] > mx) mx = perQ[k];
      if (perQ[k] < mn) mn = perQ[k];
    end
    chk(mx == 93, "R1 max period high", mx, 93);
    chk(mn == 81, "R1 min period high", mn, 81);

    finishRun();
  end

endmodule